// File: doc/BRIEF.md
# DDR Memory-Bus Manual Transfer Engine

This block runs a single software-triggered transaction on an 8-bit double-data-rate memory bus of the HyperBus kind. Software fills a small register set: a command byte with an extension byte, a byte address, a lane-enable mask that sets the transfer length, and a latency count. For writes it also fills one or two 32-bit write-data words. Writing the control word with the go bit and a direction bit starts the transaction. The engine pulls chip select low and drives the bus clock. It then sends a 48-bit command-address word, one byte per clock edge.

On a write, the data bytes follow the command-address bytes at once. On a read, the engine first waits out the programmed latency. It then captures one byte each time the read strobe from the memory changes level, and places the bytes into read-data words. The status bit is low while a transaction is in flight. It returns high once chip select has been released.

The engine has one clock. Each engine cycle is one bus clock edge, so a full bus clock period spans two engine cycles. Register writes are refused while a transaction runs. This covers every register, including the control word.

Top module: `hbx_engine`

## Requirements
- R1: After reset: `bus_cs_n`=1, `bus_ck`=0, `bus_dq_oe`=0, status bit 0 reads 1, and the command, config and read-data words read 0.
- R2: A start happens only on a write to offset 3 with bit 0 (go) set together with bit 1 (write) or bit 2 (read). When bits 1 and 2 are both set, a read runs. Writes to offset 3 that lack go, or that lack both direction bits, start nothing.
- R3: The first six bytes after start are the 48-bit word {command byte (offset 0 bits 7:0), extension byte (offset 0 bits 15:8), 0, byte address (offset 1) bits 31:1}, sent most significant byte first. The command's bit 7 therefore leaves as word bit 47. These bytes go out on six consecutive cycles with `bus_dq_oe`=1. `bus_ck` is 1 on the first byte and alternates on every active cycle.
- R4: The data length B in bytes is twice the number of set bits in the lane mask (offset 2 bits 3:0). So 0x8 gives 2, 0xC gives 4 and 0xF gives 8. A zero mask skips the data phase.
- R5: On a read, the latency field (offset 2 bits 11:8) holding N inserts 2N cycles between the last command-address byte and the first data-capture cycle. Strobe changes inside that window are ignored. A write never inserts latency, whatever N holds.
- R6: Write data byte k (k from 0) is taken from bits 63-8k down to 56-8k of {word at offset 4, word at offset 5}. Bytes go out on consecutive cycles straight after the command-address bytes, with `bus_dq_oe`=1.
- R7: During the read data phase, `bus_dq_i` is captured on each cycle where `bus_rwds_i` differs from its value one cycle earlier. Byte k lands at bits 63-8k down to 56-8k of {offset 6, offset 7}. Every start clears both read words, so unfilled bytes read 0.
- R8: `bus_cs_n` is low from the cycle after the start through exactly one cycle after the last data byte: 7+2N+B cycles on a read and 7+B cycles on a write. While `bus_cs_n` is high, `bus_dq_oe` and `bus_ck` are 0.
- R9: Status bit 0 (read at offset 3) is 0 while a transaction is in flight and 1 when the engine is idle.
- R10: While a transaction is in flight, every register write is ignored, including a new start. The running transaction completes unchanged.
- R11: `bus_ck_n` is always the complement of `bus_ck`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Engine clock; one cycle per bus clock edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register word offset for reads and writes |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational on `reg_addr`) |
| bus_cs_n | output | 1 | Chip select, active low |
| bus_ck | output | 1 | Bus clock, true phase |
| bus_ck_n | output | 1 | Bus clock, complement phase |
| bus_dq_o | output | 8 | Data bus drive value |
| bus_dq_oe | output | 1 | Data bus drive enable; 0 means released |
| bus_dq_i | input | 8 | Data bus sampled value |
| bus_rwds_i | input | 1 | Read strobe from the memory |

## Verification
The hardest case to reach from the ports is a strobe that already toggles inside the latency window. Another is a register write or second start that lands while a transaction is in flight. The bench's memory model toggles the strobe and presents a new byte on every cycle once the engine releases the bus. Latency cycles therefore offer bytes that must be skipped, and any off-by-one in the latency count shifts the whole read word. Separately, a read with the longest latency keeps the engine busy long enough for the bench to rewrite the command, config and control words mid-flight. Afterwards it confirms that the read-back values and the chip-select length are unchanged.

// File: rtl/hbx_pkg.sv
package hbx_pkg;

   typedef enum logic [2:0] {
      S_IDLE,
      S_CA,
      S_DLY,
      S_DAT,
      S_END
   } hbx_state_e;

   localparam int CA_BYTES = 6;

   localparam logic [2:0] OFF_CMD = 3'd0;
   localparam logic [2:0] OFF_ADR = 3'd1;
   localparam logic [2:0] OFF_CFG = 3'd2;
   localparam logic [2:0] OFF_CTL = 3'd3;
   localparam logic [2:0] OFF_WD0 = 3'd4;
   localparam logic [2:0] OFF_WD1 = 3'd5;
   localparam logic [2:0] OFF_RD0 = 3'd6;
   localparam logic [2:0] OFF_RD1 = 3'd7;

   localparam int BIT_GO = 0;
   localparam int BIT_WR = 1;
   localparam int BIT_RD = 2;

   localparam int CFG_DLY_LSB = 8;

endpackage

// File: rtl/hbx_regs.sv
module hbx_regs
   import hbx_pkg::*;
#(
   parameter int LANES   = 4,
   parameter int DUMMY_W = 4,
   parameter int DBITS   = 64,
   parameter int NW      = 2
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               we,
   input  logic [2:0]         waddr,
   input  logic [31:0]        wdata,
   input  logic               idle,
   output logic [7:0]         cmd_q,
   output logic [7:0]         ext_q,
   output logic [31:0]        adr_q,
   output logic [LANES-1:0]   mask_q,
   output logic [DUMMY_W-1:0] dly_q,
   output logic [DBITS-1:0]   wd_q,
   output logic               start,
   output logic               start_rd
);

   logic wr_ok;

   assign wr_ok    = we && idle;
   assign start    = wr_ok && (waddr == OFF_CTL) && wdata[BIT_GO] &&
                     (wdata[BIT_WR] || wdata[BIT_RD]);
   assign start_rd = wdata[BIT_RD];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cmd_q  <= '0;
         ext_q  <= '0;
         adr_q  <= '0;
         mask_q <= '0;
         dly_q  <= '0;
         wd_q   <= '0;
      end else if (wr_ok) begin
         if (waddr == OFF_CMD) begin
            cmd_q <= wdata[7:0];
            ext_q <= wdata[15:8];
         end
         if (waddr == OFF_ADR) adr_q <= wdata;
         if (waddr == OFF_CFG) begin
            mask_q <= wdata[LANES-1:0];
            dly_q  <= wdata[CFG_DLY_LSB +: DUMMY_W];
         end
         for (int i = 0; i < NW; i++) begin
            if (waddr == OFF_WD0 + 3'(i)) wd_q[DBITS-1-32*i -: 32] <= wdata;
         end
      end
   end

   AST_LOCKED_WHEN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      !idle |=> ($stable(cmd_q) && $stable(ext_q) && $stable(adr_q) &&
                 $stable(mask_q) && $stable(dly_q) && $stable(wd_q))); // R10

endmodule

// File: rtl/hbx_seq.sv
module hbx_seq
   import hbx_pkg::*;
#(
   parameter int LANES   = 4,
   parameter int DUMMY_W = 4,
   parameter int CNT_W   = 5
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               start,
   input  logic               start_rd,
   input  logic [LANES-1:0]   mask,
   input  logic [DUMMY_W-1:0] dly,
   input  logic               rwds_i,
   output hbx_state_e         state,
   output logic [CNT_W-1:0]   idx,
   output logic               rd_mode,
   output logic               cap,
   output logic               tog
);

   logic [CNT_W-1:0] nb;
   logic [CNT_W-1:0] dly_last;
   logic             rwds_q;
   logic             edge_seen;
   logic             adv;
   logic             active;

   always_comb begin
      nb = '0;
      for (int i = 0; i < LANES; i++) nb = nb + CNT_W'(mask[i]);
      nb = nb << 1;
   end

   assign dly_last  = CNT_W'({dly, 1'b0}) - 1'b1;
   assign edge_seen = rwds_i != rwds_q;
   assign adv       = rd_mode ? edge_seen : 1'b1;
   assign cap       = (state == S_DAT) && rd_mode && edge_seen;
   assign active    = state inside {S_CA, S_DLY, S_DAT};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state   <= S_IDLE;
         idx     <= '0;
         rd_mode <= 1'b0;
         tog     <= 1'b0;
         rwds_q  <= 1'b0;
      end else begin
         rwds_q <= rwds_i;
         case (state)
            S_IDLE: begin
               if (start) begin
                  state   <= S_CA;
                  idx     <= '0;
                  tog     <= 1'b1;
                  rd_mode <= start_rd;
               end
            end
            S_CA: begin
               tog <= ~tog;
               if (idx == CNT_W'(CA_BYTES - 1)) begin
                  idx <= '0;
                  if (rd_mode && (dly != '0)) state <= S_DLY;
                  else if (nb == '0)          state <= S_END;
                  else                        state <= S_DAT;
               end else begin
                  idx <= idx + 1'b1;
               end
            end
            S_DLY: begin
               tog <= ~tog;
               if (idx == dly_last) begin
                  idx   <= '0;
                  state <= (nb == '0) ? S_END : S_DAT;
               end else begin
                  idx <= idx + 1'b1;
               end
            end
            S_DAT: begin
               tog <= ~tog;
               if (adv) begin
                  if (idx == nb - 1'b1) begin
                     idx   <= '0;
                     state <= S_END;
                  end else begin
                     idx <= idx + 1'b1;
                  end
               end
            end
            default: begin
               state <= S_IDLE;
               tog   <= 1'b0;
            end
         endcase
      end
   end

   AST_CA_SIX_BYTES: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(state) == S_CA && state != S_CA) |-> $past(idx) == CNT_W'(CA_BYTES - 1)); // R3
   AST_DDR_ALTERNATE: assert property (@(posedge clk) disable iff (!rst_n)
      (active && $past(active)) |-> tog != $past(tog)); // R3
   AST_WRITE_NO_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(state) == S_CA && !rd_mode) |-> state != S_DLY); // R5
   AST_RELEASE_AFTER_ONE: assert property (@(posedge clk) disable iff (!rst_n)
      state == S_END |=> state == S_IDLE); // R8

endmodule

// File: rtl/hbx_dq.sv
module hbx_dq
   import hbx_pkg::*;
#(
   parameter int DBITS = 64,
   parameter int CNT_W = 5
) (
   input  logic             clk,
   input  logic             rst_n,
   input  hbx_state_e       state,
   input  logic [CNT_W-1:0] idx,
   input  logic             rd_mode,
   input  logic             cap,
   input  logic             start,
   input  logic [7:0]       cmd,
   input  logic [7:0]       ext,
   input  logic [31:1]      adr_w,
   input  logic [DBITS-1:0] wd,
   input  logic [7:0]       dq_i,
   output logic [7:0]       dq_o,
   output logic             dq_oe,
   output logic [DBITS-1:0] rd_q
);

   localparam int MAX_B = DBITS / 8;

   logic [47:0]      ca_w;
   logic [47:0]      ca_sh;
   logic [DBITS-1:0] wd_sh;

   assign ca_w  = {cmd, ext, 1'b0, adr_w};
   assign ca_sh = ca_w << {idx, 3'b000};
   assign wd_sh = wd << {idx, 3'b000};
   assign dq_oe = (state == S_CA) || ((state == S_DAT) && !rd_mode);

   always_comb begin
      if (state == S_CA)      dq_o = ca_sh[47 -: 8];
      else if (dq_oe)         dq_o = wd_sh[DBITS-1 -: 8];
      else                    dq_o = 8'h00;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_q <= '0;
      end else if (start) begin
         rd_q <= '0;
      end else if (cap) begin
         for (int k = 0; k < MAX_B; k++) begin
            if (idx == CNT_W'(k)) rd_q[DBITS-1-8*k -: 8] <= dq_i;
         end
      end
   end

   AST_READ_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
      $past(start) |-> rd_q == '0); // R7

endmodule

// File: rtl/hbx_engine.sv
module hbx_engine
   import hbx_pkg::*;
#(
   parameter int LANES   = 4,
   parameter int DUMMY_W = 4
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        reg_we,
   input  logic [2:0]  reg_addr,
   input  logic [31:0] reg_wdata,
   output logic [31:0] reg_rdata,
   output logic        bus_cs_n,
   output logic        bus_ck,
   output logic        bus_ck_n,
   output logic [7:0]  bus_dq_o,
   output logic        bus_dq_oe,
   input  logic [7:0]  bus_dq_i,
   input  logic        bus_rwds_i
);

   localparam int MAX_B    = 2 * LANES;
   localparam int DBITS    = 8 * MAX_B;
   localparam int NW       = DBITS / 32;
   localparam int DLY_SPAN = 2 * ((1 << DUMMY_W) - 1);
   localparam int SPAN_A   = (DLY_SPAN > CA_BYTES) ? DLY_SPAN : CA_BYTES;
   localparam int SPAN     = (SPAN_A > MAX_B) ? SPAN_A : MAX_B;
   localparam int CNT_W    = $clog2(SPAN + 1);

   generate
      if (LANES % 2 != 0 || LANES < 2 || LANES > 4) begin : g_bad_lanes
         $error("hbx_engine: LANES must be 2 or 4");
      end
      if (DUMMY_W < 1 || DUMMY_W > 6) begin : g_bad_dummy
         $error("hbx_engine: DUMMY_W must lie in 1..6");
      end
   endgenerate

   hbx_state_e         state;
   logic [CNT_W-1:0]   idx;
   logic               rd_mode, cap, tog, start, start_rd, idle;
   logic [7:0]         cmd_q, ext_q;
   logic [31:0]        adr_q;
   logic [LANES-1:0]   mask_q;
   logic [DUMMY_W-1:0] dly_q;
   logic [DBITS-1:0]   wd_q, rd_q;
   logic [63:0]        wd_pad, rd_pad;

   assign idle = (state == S_IDLE);

   hbx_regs #(.LANES(LANES), .DUMMY_W(DUMMY_W), .DBITS(DBITS), .NW(NW)) u_regs (
      .clk(clk), .rst_n(rst_n), .we(reg_we), .waddr(reg_addr), .wdata(reg_wdata),
      .idle(idle), .cmd_q(cmd_q), .ext_q(ext_q), .adr_q(adr_q), .mask_q(mask_q),
      .dly_q(dly_q), .wd_q(wd_q), .start(start), .start_rd(start_rd)
   );

   hbx_seq #(.LANES(LANES), .DUMMY_W(DUMMY_W), .CNT_W(CNT_W)) u_seq (
      .clk(clk), .rst_n(rst_n), .start(start), .start_rd(start_rd), .mask(mask_q),
      .dly(dly_q), .rwds_i(bus_rwds_i), .state(state), .idx(idx), .rd_mode(rd_mode),
      .cap(cap), .tog(tog)
   );

   hbx_dq #(.DBITS(DBITS), .CNT_W(CNT_W)) u_dq (
      .clk(clk), .rst_n(rst_n), .state(state), .idx(idx), .rd_mode(rd_mode),
      .cap(cap), .start(start), .cmd(cmd_q), .ext(ext_q), .adr_w(adr_q[31:1]),
      .wd(wd_q), .dq_i(bus_dq_i), .dq_o(bus_dq_o), .dq_oe(bus_dq_oe), .rd_q(rd_q)
   );

   assign bus_cs_n = idle || (state == S_END) ? idle : 1'b0;
   assign bus_ck   = tog && (state inside {S_CA, S_DLY, S_DAT});
   assign bus_ck_n = ~bus_ck;

   assign wd_pad = 64'(wd_q) << (64 - DBITS);
   assign rd_pad = 64'(rd_q) << (64 - DBITS);

   always_comb begin
      case (reg_addr)
         OFF_CMD: reg_rdata = {16'h0000, ext_q, cmd_q};
         OFF_ADR: reg_rdata = adr_q;
         OFF_CFG: reg_rdata = (32'(dly_q) << CFG_DLY_LSB) | 32'(mask_q);
         OFF_CTL: reg_rdata = {31'h0, idle};
         OFF_WD0: reg_rdata = wd_pad[63:32];
         OFF_WD1: reg_rdata = wd_pad[31:0];
         OFF_RD0: reg_rdata = rd_pad[63:32];
         default: reg_rdata = rd_pad[31:0];
      endcase
   end

   AST_BUS_QUIET_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      bus_cs_n |-> (!bus_dq_oe && !bus_ck)); // R8
   AST_STATUS_TRACKS_CS: assert property (@(posedge clk) disable iff (!rst_n)
      (!bus_cs_n && $past(!bus_cs_n)) |-> !reg_rdata[0] || reg_addr != OFF_CTL); // R9

endmodule

// File: tb/tb_hbx_engine.sv
module tb_hbx_engine;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_we = 1'b0;
   logic [2:0]  reg_addr = 3'd0;
   logic [31:0] reg_wdata = 32'h0;
   logic [31:0] reg_rdata;
   logic        bus_cs_n, bus_ck, bus_ck_n, bus_dq_oe;
   logic [7:0]  bus_dq_o;
   logic [7:0]  bus_dq_i = 8'h00;
   logic        bus_rwds_i = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   hbx_engine dut (
      .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .bus_cs_n(bus_cs_n),
      .bus_ck(bus_ck), .bus_ck_n(bus_ck_n), .bus_dq_o(bus_dq_o),
      .bus_dq_oe(bus_dq_oe), .bus_dq_i(bus_dq_i), .bus_rwds_i(bus_rwds_i)
   );

   int n_chk = 0;
   int n_bad = 0;
   int cs_cnt = 0;
   int ocnt = 0;
   int mk = 0;
   int seed = 0;
   bit quiet_bad = 0;
   bit ckn_bad = 0;
   logic [7:0] obuf [64];
   logic       ock [64];

   function automatic logic [7:0] pat(int k);
      return 8'(k * 53 + seed * 7 + 29);
   endfunction

   task automatic chk(bit ok, string req, string what, logic [63:0] act, logic [63:0] exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   // bus monitor and memory model
   always @(negedge clk) begin
      if (bus_ck_n !== ~bus_ck) ckn_bad = 1;
      if (bus_cs_n && (bus_dq_oe || bus_ck)) quiet_bad = 1;
      if (!bus_cs_n) begin
         cs_cnt++;
         if (bus_dq_oe && ocnt < 64) begin
            obuf[ocnt] = bus_dq_o;
            ock[ocnt] = bus_ck;
            ocnt++;
         end
      end
      if (!bus_cs_n && !bus_dq_oe) begin
         bus_dq_i = pat(mk);
         bus_rwds_i = ~bus_rwds_i;
         mk++;
      end else begin
         mk = 0;
      end
   end

   task automatic wr(logic [2:0] a, logic [31:0] d);
      @(negedge clk);
      reg_we = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_we = 1'b0;
   endtask

   task automatic rd(logic [2:0] a, output logic [31:0] v);
      @(negedge clk);
      reg_addr = a;
      #1 v = reg_rdata;
   endtask

   task automatic wait_idle(output bit ok);
      logic [31:0] v;
      ok = 0;
      for (int i = 0; i < 400; i++) begin
         rd(3'd3, v);
         if (v[0]) begin ok = 1; break; end
      end
   endtask

   task automatic xfer(bit is_rd, logic [7:0] cmd, logic [7:0] ext, logic [31:0] ba,
                       logic [3:0] mask, logic [3:0] dly, logic [31:0] w0, logic [31:0] w1, int sd);
      logic [47:0] ca;
      logic [63:0] dat, exp_rd, got;
      logic [31:0] r0, r1;
      int b, n;
      bit ok, good;
      b = 2 * $countones(mask);
      n = is_rd ? int'(dly) : 0;
      ca = {cmd, ext, 1'b0, ba[31:1]};
      dat = {w0, w1};
      wr(3'd0, {16'h0, ext, cmd});
      wr(3'd1, ba);
      wr(3'd2, {20'h0, dly, 4'h0, mask});
      wr(3'd4, w0);
      wr(3'd5, w1);
      seed = sd;
      cs_cnt = 0; ocnt = 0; quiet_bad = 0; ckn_bad = 0;
      wr(3'd3, is_rd ? 32'h5 : 32'h3);
      wait_idle(ok);
      chk(ok, "R9", "status returned to idle", 64'(ok), 64'd1);
      chk(ocnt == 6 + (is_rd ? 0 : b), "R4", "driven byte count", 64'(ocnt), 64'(6 + (is_rd ? 0 : b)));
      good = 1;
      for (int j = 0; j < 6; j++) if (obuf[j] !== ca[47-8*j -: 8]) good = 0;
      chk(good, "R3", "command-address bytes", {obuf[0], obuf[1], obuf[2], obuf[3], obuf[4], obuf[5], 16'h0}, {ca, 16'h0});
      good = 1;
      for (int j = 0; j < ocnt; j++) if (ock[j] !== ((j % 2) == 0)) good = 0;
      chk(good, "R3", "clock phase per driven byte", 64'(ocnt), 64'(ocnt));
      if (!is_rd) begin
         good = 1;
         got = '0;
         for (int j = 0; j < b; j++) begin
            got[63-8*j -: 8] = obuf[6+j];
            if (obuf[6+j] !== dat[63-8*j -: 8]) good = 0;
         end
         chk(good, "R6", "write data bytes", got, dat & ~(64'hFFFF_FFFF_FFFF_FFFF >> (8*b)));
      end
      chk(cs_cnt == 7 + 2*n + b, "R8", "chip-select low cycles (R5 latency)", 64'(cs_cnt), 64'(7 + 2*n + b));
      exp_rd = '0;
      if (is_rd) for (int j = 0; j < b; j++) exp_rd[63-8*j -: 8] = pat(2*n + j);
      rd(3'd6, r0);
      rd(3'd7, r1);
      chk({r0, r1} === exp_rd, "R7", "read words (R5 skip)", {r0, r1}, exp_rd);
      chk(!quiet_bad, "R8", "bus quiet while deselected", 64'(quiet_bad), 64'd0);
      chk(!ckn_bad, "R11", "complement clock", 64'(ckn_bad), 64'd0);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

   initial begin
      logic [31:0] v, v2;
      bit ok;
      int dl [3] = '{0, 1, 7};
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk(bus_cs_n === 1'b1 && bus_ck === 1'b0 && bus_dq_oe === 1'b0, "R1", "bus idle after reset",
          {61'h0, bus_cs_n, bus_ck, bus_dq_oe}, 64'h4);
      rd(3'd3, v);  chk(v === 32'h1, "R1", "status after reset", 64'(v), 64'h1);
      rd(3'd0, v);  chk(v === 32'h0, "R1", "command after reset", 64'(v), 64'h0);
      rd(3'd2, v);  chk(v === 32'h0, "R1", "config after reset", 64'(v), 64'h0);
      rd(3'd6, v);  rd(3'd7, v2);
      chk({v, v2} === 64'h0, "R1", "read words after reset", {v, v2}, 64'h0);

      // R2 start encodings that must not start
      cs_cnt = 0;
      wr(3'd3, 32'h1);
      repeat (10) @(negedge clk);
      chk(cs_cnt == 0, "R2", "go without direction", 64'(cs_cnt), 64'd0);
      wr(3'd3, 32'h6);
      repeat (10) @(negedge clk);
      chk(cs_cnt == 0, "R2", "direction without go", 64'(cs_cnt), 64'd0);
      rd(3'd3, v);  chk(v[0] === 1'b1, "R2", "still idle", 64'(v), 64'h1);

      // R2 both directions: read wins (mask 0x8, latency 2)
      wr(3'd2, 32'h0000_0208);
      cs_cnt = 0; ocnt = 0;
      wr(3'd3, 32'h7);
      wait_idle(ok);
      chk(ocnt == 6, "R2", "read chosen when both set", 64'(ocnt), 64'd6);
      chk(cs_cnt == 13, "R2", "read length when both set", 64'(cs_cnt), 64'd13);

      // sweep: every lane mask, three latencies, both directions
      for (int m = 0; m < 16; m++) begin
         for (int d = 0; d < 3; d++) begin
            xfer(1'b1, 8'h80 | 8'(m), 8'(m * 17 + d), 32'h1357_9BDF ^ (32'(m) << 20) ^ 32'(d),
                 4'(m), 4'(dl[d]), 32'hA5C3_0F18 + 32'(m), 32'h6B2D_E947 ^ 32'(d), m * 3 + d);
            xfer(1'b0, 8'h20 | 8'(m), 8'(m * 5 + d), 32'h8642_0ACE + 32'(m * 4099) + 32'(d),
                 4'(m), 4'(dl[d]), 32'h0123_4567 ^ (32'(m) << 8), 32'h89AB_CDEF + 32'(d), 100 + m);
         end
      end
      xfer(1'b1, 8'hC0, 8'h00, 32'hFFFF_FFFF, 4'hF, 4'hF, 32'h0, 32'h0, 77);

      // R10 and R9: writes during a long read are ignored
      wr(3'd0, 32'h0000_33A0);
      wr(3'd2, 32'h0000_0F0F);
      cs_cnt = 0;
      wr(3'd3, 32'h5);
      rd(3'd3, v);  chk(v[0] === 1'b0, "R9", "status busy in flight", 64'(v), 64'h0);
      wr(3'd0, 32'h0000_1111);
      wr(3'd2, 32'h0000_0008);
      wr(3'd3, 32'h3);
      wait_idle(ok);
      chk(cs_cnt == 45, "R10", "in-flight read unchanged", 64'(cs_cnt), 64'd45);
      rd(3'd0, v);  chk(v === 32'h0000_33A0, "R10", "command kept", 64'(v), 64'h33A0);
      rd(3'd2, v);  chk(v === 32'h0000_0F0F, "R10", "config kept", 64'(v), 64'h0F0F);
      repeat (5) @(negedge clk);
      chk(bus_cs_n === 1'b1, "R10", "no second transaction", 64'(bus_cs_n), 64'h1);

      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end
endmodule